// File: doc/BRIEF.md
# Load/Store Alignment Fault Detector

This block judges each memory access on its own and decides whether it must raise an alignment exception. The decode stage passes in an instruction class, the two low bits of the effective address, the current byte order, and page attributes: write-through and cache-inhibited. It also passes whether address translation is on and whether the data cache is on. One cycle later the block returns a fault flag and a two-bit reason code, marked by an output valid.

A fault can come from three sources. A word-sized operand that needs word alignment may sit at an address that is not word-aligned. A multiple-word or string transfer may run in little-endian order. A cache-block-zero operation may target a page it cannot fill, or may run while the data cache is off. Ordinary integer loads and stores never fault here. Address translation, the memory access and exception dispatch belong to other blocks.

Top module: `align_fault_top`

## Requirements
- R1: Out of reset, `res_vld` is 0, `res_fault` is 0 and `res_code` is 2'b00.
- R2: `res_vld` equals `req_vld` delayed by one clock. The fault and code outputs registered with a valid request show that request's result on the same cycle as `res_vld`.
- R3: Class codes are: 0 integer load/store, 1 FP load/store, 2 load multiple, 3 store multiple, 4 string load/store, 5 load-and-reserve word, 6 store-conditional word, 7 external-control word, 8 cache-block-zero, and all other values behave as integer. Classes 1, 2, 3, 5, 6 and 7 fault with code 2'b01 when `req_ea_lo` is not 2'b00.
- R4: Classes 2, 3 and 4 fault with code 2'b10 in little-endian mode (`req_le`=1) at any address, unless R3 already matched.
- R5: Class 8 faults with code 2'b11 when `req_xlate`=1 and either `req_wt` or `req_ci` is 1.
- R6: Class 8 faults with code 2'b11 whenever `req_dc_en`=0, whatever `req_xlate` is. With `req_xlate`=0, the values of `req_wt` and `req_ci` have no effect.
- R7: Integer loads/stores (class 0 and unused codes 9..15) never fault, whatever the address, byte order and page attributes.
- R8: `res_fault` is 1 exactly when `res_code` is not 2'b00. When R3 and R4 both match, code 2'b01 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request valid |
| req_cls | input | 4 | Instruction class code |
| req_ea_lo | input | 2 | Effective address bits [1:0] |
| req_le | input | 1 | Little-endian mode |
| req_wt | input | 1 | Page is write-through |
| req_ci | input | 1 | Page is cache-inhibited |
| req_xlate | input | 1 | Data translation enabled |
| req_dc_en | input | 1 | Data cache enabled |
| res_vld | output | 1 | Result valid |
| res_fault | output | 1 | Alignment fault |
| res_code | output | 2 | Reason: 00 none, 01 misaligned, 10 LE multiple/string, 11 block-zero |

## Verification
The pipeline holds only one result register. If the class decode or the rule priority is wrong, the fault is wrong at the ports on the cycle right after the offending request, with no masking by later traffic. A valid bit stuck in the wrong state, or a code that disagrees with its flag, is likewise visible within one cycle. Random traffic across every class, address, byte order and attribute mix catches such a fault quickly, and directed cases cover the overlap of rules and the translation-off case.

// File: rtl/align_fault_pkg.sv
package align_fault_pkg;
  localparam int CLS_W  = 4;
  localparam int CODE_W = 2;

  typedef enum logic [CLS_W-1:0] {
    C_INT   = 4'd0,
    C_FP    = 4'd1,
    C_LDMUL = 4'd2,
    C_STMUL = 4'd3,
    C_STR   = 4'd4,
    C_LRSV  = 4'd5,
    C_STCND = 4'd6,
    C_EXTC  = 4'd7,
    C_BZERO = 4'd8
  } cls_e;

  typedef enum logic [CODE_W-1:0] {
    RC_NONE  = 2'b00,
    RC_MISAL = 2'b01,
    RC_LEMS  = 2'b10,
    RC_BZERO = 2'b11
  } code_e;

  typedef struct packed {
    logic word_req;
    logic multi_str;
    logic bzero;
  } cls_attr_t;

  function automatic cls_attr_t decode_cls(input logic [CLS_W-1:0] c);
    cls_attr_t a;
    a.word_req  = (c == C_FP) || (c == C_LDMUL) || (c == C_STMUL) ||
                  (c == C_LRSV) || (c == C_STCND) || (c == C_EXTC);
    a.multi_str = (c == C_LDMUL) || (c == C_STMUL) || (c == C_STR);
    a.bzero     = (c == C_BZERO);
    return a;
  endfunction
endpackage

// File: rtl/align_cls_decode.sv
module align_cls_decode
  import align_fault_pkg::*;
#(
  parameter int CW = CLS_W
) (
  input  logic [CW-1:0] cls,
  output cls_attr_t     attr
);
  always_comb attr = decode_cls(cls);
endmodule

// File: rtl/align_rule_eval.sv
module align_rule_eval
  import align_fault_pkg::*;
#(
  parameter int EA_W = 2
) (
  input  cls_attr_t       attr,
  input  logic [EA_W-1:0] ea_lo,
  input  logic            le,
  input  logic            wt,
  input  logic            ci,
  input  logic            xlate,
  input  logic            dc_en,
  output logic            hit_misal,
  output logic            hit_lems,
  output logic            hit_bzero,
  output code_e           code
);
  always_comb begin
    hit_misal = attr.word_req && (ea_lo != '0);
    hit_lems  = attr.multi_str && le;
    hit_bzero = attr.bzero && ((xlate && (wt || ci)) || !dc_en);
    if (hit_misal)      code = RC_MISAL;
    else if (hit_lems)  code = RC_LEMS;
    else if (hit_bzero) code = RC_BZERO;
    else                code = RC_NONE;
  end
endmodule

// File: rtl/align_fault_top.sv
module align_fault_top
  import align_fault_pkg::*;
#(
  parameter int CW   = CLS_W,
  parameter int EA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [CW-1:0]   req_cls,
  input  logic [EA_W-1:0] req_ea_lo,
  input  logic            req_le,
  input  logic            req_wt,
  input  logic            req_ci,
  input  logic            req_xlate,
  input  logic            req_dc_en,
  output logic            res_vld,
  output logic            res_fault,
  output logic [CODE_W-1:0] res_code
);
  cls_attr_t attr_w;
  logic hit_misal_w, hit_lems_w, hit_bzero_w;
  code_e code_w;

  align_cls_decode #(.CW(CW)) u_dec (.cls(req_cls), .attr(attr_w));

  align_rule_eval #(.EA_W(EA_W)) u_eval (
    .attr(attr_w), .ea_lo(req_ea_lo), .le(req_le), .wt(req_wt), .ci(req_ci),
    .xlate(req_xlate), .dc_en(req_dc_en),
    .hit_misal(hit_misal_w), .hit_lems(hit_lems_w), .hit_bzero(hit_bzero_w),
    .code(code_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_fault <= 1'b0;
      res_code  <= RC_NONE;
    end else begin
      res_vld <= req_vld;
      if (req_vld) begin
        res_fault <= (code_w != RC_NONE);
        res_code  <= code_w;
      end
    end
  end

  // R2
  vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(req_vld));
  // R8
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault == (res_code != 2'b00));
  // R8
  misal_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && hit_misal_w) |=> (res_code == 2'b01));
  // R7
  int_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !attr_w.word_req && !attr_w.multi_str && !attr_w.bzero)
      |=> !res_fault);
  // R6
  dc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && attr_w.bzero && !req_dc_en) |=> (res_code == 2'b11));
  // R4
  lems_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && hit_lems_w && !hit_misal_w) |=> (res_code == 2'b10));
endmodule

// File: tb/sim_align_fault_top.sv
module sim_align_fault_top;
  logic clk = 1'b0;
  logic rst_n;
  logic req_vld, req_le, req_wt, req_ci, req_xlate, req_dc_en;
  logic [3:0] req_cls;
  logic [1:0] req_ea_lo;
  logic res_vld, res_fault;
  logic [1:0] res_code;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  align_fault_top u0 (.*);

  function automatic logic [1:0] model(input logic [3:0] c, input logic [1:0] ea,
      input logic le, wt, ci, xl, dc);
    logic word, ms, bz;
    word = (c inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7});
    ms   = (c inside {4'd2, 4'd3, 4'd4});
    bz   = (c == 4'd8);
    if (word && ea != 2'b00) return 2'b01;
    if (ms && le) return 2'b10;
    if (bz && (!dc || (xl && (wt | ci)))) return 2'b11;
    return 2'b00;
  endfunction

  task automatic chk(input string r, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic apply(input string r, input logic [3:0] c, input logic [1:0] ea,
      input logic le, wt, ci, xl, dc);
    logic [1:0] e;
    @(negedge clk);
    req_vld = 1; req_cls = c; req_ea_lo = ea; req_le = le;
    req_wt = wt; req_ci = ci; req_xlate = xl; req_dc_en = dc;
    e = model(c, ea, le, wt, ci, xl, dc);
    @(negedge clk);
    req_vld = 0;
    chk({r, " vld"}, {3'b0, res_vld}, 4'd1);
    chk({r, " code"}, {2'b0, res_code}, {2'b0, e});
    chk({r, " flag"}, {3'b0, res_fault}, {3'b0, e != 2'b00});
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; req_vld = 0; req_cls = 0; req_ea_lo = 0; req_le = 0;
    req_wt = 0; req_ci = 0; req_xlate = 0; req_dc_en = 1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 vld", {3'b0, res_vld}, 0);
    chk("R1 flag", {3'b0, res_fault}, 0);
    chk("R1 code", {2'b0, res_code}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2: idle gives no valid
    chk("R2 idle", {3'b0, res_vld}, 0);
    apply("R3 fp misal", 4'd1, 2'b10, 0, 0, 0, 1, 1);
    apply("R3 lrsv ok", 4'd5, 2'b00, 0, 0, 0, 1, 1);
    apply("R3 extc misal", 4'd7, 2'b01, 0, 0, 0, 0, 1);
    apply("R4 string le", 4'd4, 2'b11, 1, 0, 0, 0, 1);
    apply("R8 ldmul both", 4'd2, 2'b01, 1, 0, 0, 0, 1);
    apply("R4 stmul le", 4'd3, 2'b00, 1, 0, 0, 0, 1);
    apply("R5 bzero wt", 4'd8, 2'b00, 0, 1, 0, 1, 1);
    apply("R5 bzero ci", 4'd8, 2'b00, 0, 0, 1, 1, 1);
    apply("R6 bzero xlate off", 4'd8, 2'b00, 0, 1, 1, 0, 1);
    apply("R6 bzero dc off", 4'd8, 2'b00, 0, 0, 0, 0, 0);
    apply("R7 int", 4'd0, 2'b11, 1, 1, 1, 1, 0);
    apply("R7 unused", 4'd12, 2'b01, 1, 1, 1, 1, 0);
    // R2: held outputs after an idle cycle, valid drops
    @(negedge clk);
    chk("R2 drop", {3'b0, res_vld}, 0);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      apply("R3-R8 random", 4'($urandom_range(0, 15)), r[1:0], r[2], r[3], r[4], r[5],
            r[6] | r[7]);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule